// File: doc/BRIEF.md
# PCI Slot Interrupt Router with Legacy Routing Detection

This block collects the level-sensitive INTA..INTD requests of three PCI slots (slot numbers 29, 30 and 31) and folds them onto four system interrupt lines. In its normal routing, each request is rotated by the slot number plus a fixed offset. The offset is chosen by a static board-variant strap. Requests that land on the same line are ORed together, so shared level interrupts still work.

Some host software expects a plain identity routing instead. To support it, the block watches configuration-space writes that go to a device's interrupt-line byte. While it is still undecided, the value written tells it which routing that software expects. The first relevant write settles the choice, and the choice then holds until reset. The current routing mode is brought out on a port so that it can be observed.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, `route_mode` reads 0 (undecided). The outputs follow the rotated routing.
- R2: The request for pin n (INTA=0 .. INTD=3) of slot 29+i sits at `irq_req` bit 4*i+n. In modes 0 (undecided) and 2 (native), that request drives `irq_out[(s+n+k) mod 4]`. Here s is the slot number, k=2 when `board_sel`=0 and k=3 when `board_sel`=1.
- R3: Once `route_mode` is 1 (legacy) or 2 (native), it keeps that value until the next reset, whatever is written.
- R4: A decision is made on a write when all of the following hold:
  - `route_mode` is 0 and `board_sel` is 0;
  - `cfg_wr_en` is high;
  - `cfg_addr[7:0]` is 0x3C and `cfg_be[0]` is set;
  - the slot number `cfg_addr[15:11]` is not 2 modulo 4.

  If `cfg_wdata[7:0]` is 27, `route_mode` becomes 1 on the next clock. For any other value it becomes 2.
- R5: A write to the interrupt-line byte whose slot number is 2 modulo 4 (for example slot 30) leaves `route_mode` unchanged.
- R6: With `board_sel`=1, no write moves `route_mode` out of 0.
- R7: In mode 1, pin n of any slot drives `irq_out[n]`.
- R8: Each `irq_out` line is the OR of all requests currently routed to it. No request means all outputs are low.
- R9: A write with `cfg_be[0]` clear, or with `cfg_addr[7:0]` other than 0x3C, leaves `route_mode` unchanged.
- R10: `irq_out` is a combinational function of `irq_req` and the current mode. It switches routing in the same cycle that `route_mode` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| board_sel | input | 1 | Static board-variant strap (0: offset 2 with detection, 1: offset 3) |
| irq_req | input | 12 | Per-slot, per-pin level requests, bit 4*i+n = slot 29+i pin n |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 24 | Configuration address; [15:8] device/function, [7:0] register byte |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables of the write data |
| irq_out | output | 4 | System interrupt lines |
| route_mode | output | 2 | Routing mode: 0 undecided, 1 legacy, 2 native |

## Verification
The bench drives every single-pin request on both board variants, and it also drives overlapping requests. A wrong rotation offset or a missing OR would show up on the wrong line or drop a shared interrupt. Writes are aimed at the corner cases of the detector:
- a slot where both routings agree;
- a write that does not cover the interrupt-line byte;
- a write to another register;
- the second board variant.

A detector that fired on any of these would leave the undecided mode. A second write after the decision tests stickiness: a non-sticky detector would flip between legacy and native. In legacy mode the bench confirms that the identity mapping replaces the rotation at once.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  typedef enum logic [1:0] {
    MODE_PROBE  = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_NATIVE = 2'd2
  } route_mode_e;

  localparam int unsigned INTX_PINS      = 4;
  localparam logic [7:0]  INTLINE_OFFSET = 8'h3C;

endpackage

// File: rtl/pci_irq_mode_detect.sv
module pci_irq_mode_detect
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter logic [7:0]  LEGACY_CODE = 8'd27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  input  logic              wbyte_en,
  output route_mode_e       mode
);

  logic [4:0]  slot_num;
  logic        slot_differs;
  logic        line_hit;
  logic        decide;
  route_mode_e mode_q;
  route_mode_e mode_d;
  logic        mode_upd;

  // slot number is the top five bits of the device/function byte
  assign slot_num     = addr[15:11];
  assign slot_differs = (slot_num[1:0] != 2'd2);
  assign line_hit     = wr_en && wbyte_en && (addr[7:0] == INTLINE_OFFSET);
  assign decide       = detect_en && line_hit && slot_differs && (mode_q == MODE_PROBE);

  always_comb begin
    mode_d = mode_q;
    if (decide) begin
      if (wbyte == LEGACY_CODE) mode_d = MODE_LEGACY;
      else                      mode_d = MODE_NATIVE;
    end
  end

  assign mode_upd = decide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_PROBE;
    else if (mode_upd) mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_PROBE) |=> (mode_q == $past(mode_q))) else $error("sticky"); // R3

  AST_LEGACY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROBE && detect_en && line_hit && slot_differs && wbyte == LEGACY_CODE)
    |=> (mode_q == MODE_LEGACY)) else $error("legacy"); // R4

  AST_SAME_SLOT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROBE && !slot_differs) |=> (mode_q == MODE_PROBE)) else $error("slot"); // R5

  AST_VARIANT_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROBE && !detect_en) |=> (mode_q == MODE_PROBE)) else $error("variant"); // R6

  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROBE && wr_en && !wbyte_en) |=> (mode_q == MODE_PROBE)) else $error("be"); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd3)) else $error("illegal"); // R3

endmodule

// File: rtl/pci_irq_slot_swizzle.sv
module pci_irq_slot_swizzle
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned SLOT_NUM = 29
) (
  input  logic [INTX_PINS-1:0] pin_req,
  input  logic [1:0]           rot_offset,
  input  logic                 identity,
  output logic [INTX_PINS-1:0] line_req
);

  localparam logic [1:0] SLOT_BASE = 2'(SLOT_NUM % INTX_PINS);

  logic [1:0] target [INTX_PINS];

  for (genvar n = 0; n < INTX_PINS; n++) begin : g_pin
    always_comb begin
      if (identity) target[n] = 2'(n);
      else          target[n] = SLOT_BASE + 2'(n) + rot_offset;
    end
  end

  always_comb begin
    line_req = '0;
    for (int n = 0; n < INTX_PINS; n++) begin
      if (pin_req[n]) line_req[target[n]] = 1'b1;
    end
  end

  AST_SWIZZLE_COUNT: assert final ($countones(line_req) <= $countones(pin_req)); // R2

endmodule

// File: rtl/pci_irq_line_merge.sv
module pci_irq_line_merge
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic [NUM_SLOTS*INTX_PINS-1:0] slot_lines,
  output logic [INTX_PINS-1:0]           irq_lines
);

  for (genvar l = 0; l < INTX_PINS; l++) begin : g_line
    logic [NUM_SLOTS-1:0] contrib;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign contrib[s] = slot_lines[s*INTX_PINS + l];
    end
    assign irq_lines[l] = |contrib;
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 3,
  parameter int unsigned FIRST_SLOT  = 29,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 32,
  parameter logic [7:0]  LEGACY_CODE = 8'd27
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          board_sel,
  input  logic [NUM_SLOTS*INTX_PINS-1:0] irq_req,
  input  logic                          cfg_wr_en,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic [DATA_W/8-1:0]           cfg_be,
  output logic [INTX_PINS-1:0]          irq_out,
  output logic [1:0]                    route_mode
);

  localparam int unsigned REQ_W = NUM_SLOTS * INTX_PINS;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  route_mode_e      mode;
  logic [1:0]       rot_offset;
  logic             identity;
  logic [REQ_W-1:0] slot_lines;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pci_irq_mode_detect #(
    .ADDR_W      (ADDR_W),
    .LEGACY_CODE (LEGACY_CODE)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .detect_en (!board_sel),
    .wr_en     (cfg_wr_en),
    .addr      (cfg_addr),
    .wbyte     (cfg_wdata[7:0]),
    .wbyte_en  (cfg_be[0]),
    .mode      (mode)
  );

  assign rot_offset = board_sel ? 2'd3 : 2'd2;
  assign identity   = (mode == MODE_LEGACY);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    pci_irq_slot_swizzle #(
      .SLOT_NUM (FIRST_SLOT + i)
    ) u_swz (
      .pin_req    (irq_req[i*INTX_PINS +: INTX_PINS]),
      .rot_offset (rot_offset),
      .identity   (identity),
      .line_req   (slot_lines[i*INTX_PINS +: INTX_PINS])
    );
  end

  pci_irq_line_merge #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_merge (
    .slot_lines (slot_lines),
    .irq_lines  (irq_out)
  );

  assign route_mode = mode;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_req == '0) |-> (irq_out == '0)) else $error("idle"); // R8

  AST_SINGLE_REQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($countones(irq_req) == 1) |-> ($countones(irq_out) == 1)) else $error("single"); // R2

  AST_LEGACY_IDENTITY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (route_mode == 2'd1 && irq_req[INTX_PINS-1:0] == 4'b0001) |-> irq_out[0]) else $error("ident"); // R7

  AST_RESET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_core_n) |-> (route_mode == 2'd0)) else $error("reset"); // R1

endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        board_sel;
  logic [11:0] irq_req;
  logic        cfg_wr_en;
  logic [23:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic [3:0]  irq_out;
  logic [1:0]  route_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pci_irq_router uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .board_sel  (board_sel),
    .irq_req    (irq_req),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_be     (cfg_be),
    .irq_out    (irq_out),
    .route_mode (route_mode)
  );

  function automatic logic [3:0] exp_route(logic [11:0] req, logic [1:0] mode, logic sel);
    logic [3:0] r = '0;
    for (int i = 0; i < 3; i++) begin
      for (int n = 0; n < 4; n++) begin
        if (req[4*i+n]) begin
          if (mode == 2'd1) r[n] = 1'b1;
          else              r[(29 + i + n + (sel ? 3 : 2)) % 4] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0; board_sel = sel; irq_req = '0;
    cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_be = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [4:0] slot, input logic [7:0] reg_off,
                           input logic [7:0] val, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = {8'h00, slot, 3'b000, reg_off};
    cfg_wdata = {24'h0, val};
    cfg_be    = be;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_be    = '0;
  endtask

  task automatic check_req(input logic [11:0] req, input string tag);
    irq_req = req;
    #1;
    check(32'(irq_out), 32'(exp_route(req, route_mode, board_sel)), tag);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check(32'(route_mode), 0, "R1 reset mode");
    check(32'(irq_out), 0, "R8 idle outputs");
    check_req(12'h001, "R1 slot29 INTA after reset");
  endtask

  task automatic t_rotation;
    for (int sel = 0; sel < 2; sel++) begin
      do_reset(1'(sel));
      for (int b = 0; b < 12; b++) check_req(12'(1 << b), "R2 rotation single pin");
    end
    // explicit: slot 31 INTA -> line 1 (k=2), line 2 (k=3)
    do_reset(1'b0);
    irq_req = 12'h100; #1; check(32'(irq_out), 32'h2, "R2 slot31 INTA variant0");
    do_reset(1'b1);
    irq_req = 12'h100; #1; check(32'(irq_out), 32'h4, "R2 slot31 INTA variant1");
  endtask

  task automatic t_share;
    do_reset(1'b0);
    check_req(12'h011, "R8 shared slot29A slot30A");
    check_req(12'h00F, "R8 all pins of slot29");
    check_req(12'hA50, "R8 mixed pattern");
    check_req(12'h000, "R8 idle");
  endtask

  task automatic t_ignored;
    do_reset(1'b0);
    cfg_write(5'd30, 8'h3C, 8'd27, 4'hF);
    check(32'(route_mode), 0, "R5 slot30 write ignored");
    cfg_write(5'd31, 8'h3C, 8'd27, 4'hE);
    check(32'(route_mode), 0, "R9 byte not enabled");
    cfg_write(5'd31, 8'h40, 8'd27, 4'hF);
    check(32'(route_mode), 0, "R9 other register");
    check_req(12'h100, "R9 routing still rotated");
  endtask

  task automatic t_legacy;
    do_reset(1'b0);
    cfg_write(5'd31, 8'h3C, 8'd27, 4'h1);
    check(32'(route_mode), 1, "R4 value 27 selects legacy");
    for (int i = 0; i < 3; i++)
      for (int n = 0; n < 4; n++) begin
        irq_req = 12'(1 << (4*i+n)); #1;
        check(32'(irq_out), 32'(1 << n), "R7 identity routing");
      end
    cfg_write(5'd29, 8'h3C, 8'd9, 4'hF);
    check(32'(route_mode), 1, "R3 legacy sticky");
  endtask

  task automatic t_native;
    do_reset(1'b0);
    irq_req = 12'h001;
    cfg_write(5'd29, 8'h3C, 8'd50, 4'hF);
    check(32'(route_mode), 2, "R4 other value selects native");
    check(32'(irq_out), 32'h8, "R10 native slot29 INTA");
    cfg_write(5'd31, 8'h3C, 8'd27, 4'hF);
    check(32'(route_mode), 2, "R3 native sticky");
    check_req(12'h842, "R2 native rotation");
  endtask

  task automatic t_switch;
    do_reset(1'b0);
    irq_req = 12'h002;  // slot29 INTB: rotated line 0, identity line 1
    #1; check(32'(irq_out), 32'h1, "R10 before decision");
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = {8'h00, 5'd31, 3'b000, 8'h3C};
    cfg_wdata = 32'd27; cfg_be = 4'h1;
    @(posedge clk); #1;
    check(32'(route_mode), 1, "R10 mode changed");
    check(32'(irq_out), 32'h2, "R10 output follows mode same cycle");
    @(negedge clk); cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic t_variant2;
    do_reset(1'b1);
    cfg_write(5'd31, 8'h3C, 8'd27, 4'hF);
    check(32'(route_mode), 0, "R6 variant1 no legacy");
    cfg_write(5'd29, 8'h3C, 8'd11, 4'hF);
    check(32'(route_mode), 0, "R6 variant1 no native");
    check_req(12'h100, "R6 variant1 rotation kept");
  endtask

  initial begin
    rst_n = 1'b0; board_sel = 1'b0; irq_req = '0;
    cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_be = '0;
    t_reset();
    t_rotation();
    t_share();
    t_ignored();
    t_legacy();
    t_native();
    t_switch();
    t_variant2();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule